// File: doc/BRIEF.md
# Endian-Configurable Misaligned Load/Store Unit

This unit sits between a processor datapath and a 64-bit-wide, single-port, synchronous data memory. It takes one load or store request at a time. Each request names an operand of 1, 2, 4 or 8 bytes at any byte address. A byte-order input chosen per request decides whether the lowest-addressed byte of the operand is its most significant or its least significant byte.

When the operand lies inside one aligned 64-bit memory word, the unit makes one memory cycle. When the operand crosses into the next word, it makes two memory cycles, lower word first. For stores, the operand bytes are placed on the right memory lanes with a per-lane write mask. For loads, the bytes are collected from one or two read words, put back in operand order, and widened to 64 bits with zero or sign fill.

The datapath sees a `busy` level and a one-cycle `done` pulse. A new request may be presented in the same cycle as `done`.

Top module: `endian_lsu`

## Requirements
- R1: `req_size` codes 0, 1, 2 and 3 select operand widths of 1, 2, 4 and 8 bytes. Each width is stored and loaded correctly at every byte offset within a word.
- R2: With `req_big` = 0, the operand byte at the lowest address is its least significant byte (bits 7:0), and byte i sits at address A+i.
- R3: With `req_big` = 1, the operand byte at the lowest address is its most significant byte, and operand byte n-1-i sits at address A+i for an n-byte operand.
- R4: When `req_addr[2:0]` + n <= 8, the request makes exactly one memory cycle, to word `req_addr >> 3`. `done` is high in the third cycle after the accepting clock edge.
- R5: When `req_addr[2:0]` + n > 8, the request makes exactly two memory cycles in consecutive clocks. The first goes to word `req_addr >> 3` and the second to the word after it. `done` is high in the fourth cycle after the accepting edge.
- R6: A load returns the operand in `load_data[8n-1:0]`. With `req_signed` = 0 the upper bits are zero. With `req_signed` = 1 they copy bit 8n-1 of the operand.
- R7: On every memory cycle, `mem_be[j]` is set exactly for the lanes j (byte j of the word = address offset j) that hold an operand byte. A store drives `mem_we` with the operand byte on each enabled lane. A load keeps `mem_we` low. No lane outside the operand is written.
- R8: A request is taken only on a clock edge where `req_valid` is high and `busy` is low. `req_valid` while `busy` is high has no effect on memory. `busy` is high from the cycle after acceptance until `done`. `done` lasts one cycle.
- R9: A request presented during the `done` cycle is accepted at the next edge with no idle cycle.
- R10: Coming out of reset, `busy`, `done` and `mem_en` are low and `load_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Operand width code (0:1, 1:2, 2:4, 3:8 bytes) |
| req_signed | input | 1 | Load fill: 1 = sign, 0 = zero |
| req_big | input | 1 | Byte order: 1 = most significant byte first |
| req_addr | input | AW | Byte address |
| req_wdata | input | 64 | Store operand, right-aligned |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| load_data | output | 64 | Widened load result, valid from `done` |
| mem_en | output | 1 | Memory cycle enable |
| mem_we | output | 1 | Memory write |
| mem_addr | output | AW-3 | Memory word address |
| mem_be | output | 8 | Lane enables |
| mem_wdata | output | 64 | Lane write data |
| mem_rdata | input | 64 | Read word, one clock after the read cycle |

## Verification
Completing one request and accepting the next can happen in the same cycle. The bench always presents the next request at the falling edge where it sees `done`, so every back-to-back pair exercises this overlap. It then checks that the new request's first memory cycle follows exactly one clock later, and that the previous `load_data` is already settled at that point. A second overlap is a request held on `req_valid` throughout a busy period. That request is withdrawn at the `done` cycle, and the bench checks both the memory-cycle count and the untouched target word.

// File: rtl/lsu_pkg.sv
`timescale 1ns/1ps
package lsu_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } opsize_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LO   = 2'd1,
    ST_HI   = 2'd2,
    ST_FIN  = 2'd3
  } lsu_state_e;

  typedef struct packed {
    logic    wr;
    opsize_e size;
    logic    sgn;
    logic    big;
  } req_attr_t;

  function automatic int unsigned width_bytes(opsize_e s);
    return 32'd1 << s;
  endfunction

endpackage

// File: rtl/lsu_rst_sync.sv
`timescale 1ns/1ps
module lsu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/lsu_store_steer.sv
`timescale 1ns/1ps
module lsu_store_steer
  import lsu_pkg::*;
#(
  parameter int NB    = 8,
  parameter int OFF_W = $clog2(NB)
) (
  input  logic [OFF_W-1:0]  off,
  input  opsize_e           size,
  input  logic              big,
  input  logic [8*NB-1:0]   wdata,
  output logic [2*NB-1:0]   win_be,
  output logic [16*NB-1:0]  win_data
);

  localparam int WIN = 2 * NB;

  always_comb begin
    int n;
    int rel;
    int src;
    n        = int'(width_bytes(size));
    win_be   = '0;
    win_data = '0;
    for (int p = 0; p < WIN; p++) begin
      rel = p - int'(off);
      src = 0;
      if (rel >= 0 && rel < n) begin
        src = big ? (n - 1 - rel) : rel;
        win_be[p] = 1'b1;
        win_data[p*8 +: 8] = wdata[src*8 +: 8];
      end
    end
  end

endmodule

// File: rtl/lsu_load_gather.sv
`timescale 1ns/1ps
module lsu_load_gather
  import lsu_pkg::*;
#(
  parameter int NB    = 8,
  parameter int OFF_W = $clog2(NB)
) (
  input  logic [OFF_W-1:0]  off,
  input  opsize_e           size,
  input  logic              big,
  input  logic              sgn,
  input  logic [16*NB-1:0]  window,
  output logic [8*NB-1:0]   result
);

  logic [7:0] picked [NB];
  logic       fill;

  always_comb begin
    int n;
    int pos;
    n = int'(width_bytes(size));
    for (int k = 0; k < NB; k++) begin
      picked[k] = 8'h00;
      pos = 0;
      if (k < n) begin
        pos = int'(off) + (big ? (n - 1 - k) : k);
        picked[k] = window[pos*8 +: 8];
      end
    end
    fill = sgn & picked[n-1][7];
  end

  generate
    for (genvar g = 0; g < NB; g++) begin : g_lane
      assign result[g*8 +: 8] = (g < int'(width_bytes(size))) ? picked[g] : {8{fill}};
    end
  endgenerate

endmodule

// File: rtl/lsu_ctrl.sv
`timescale 1ns/1ps
module lsu_ctrl
  import lsu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       split,
  output lsu_state_e state
);

  lsu_state_e state_d;

  always_comb begin
    state_d = state;
    unique case (state)
      ST_IDLE: if (start) state_d = ST_LO;
      ST_LO:   state_d = split ? ST_HI : ST_FIN;
      ST_HI:   state_d = ST_FIN;
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_d;
  end

endmodule

// File: rtl/endian_lsu.sv
`timescale 1ns/1ps
module endian_lsu
  import lsu_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [1:0]      req_size,
  input  logic            req_signed,
  input  logic            req_big,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  output logic            busy,
  output logic            done,
  output logic [DW-1:0]   load_data,
  output logic            mem_en,
  output logic            mem_we,
  output logic [AW-4:0]   mem_addr,
  output logic [7:0]      mem_be,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata
);

  localparam int NB    = DW / 8;
  localparam int OFF_W = $clog2(NB);
  localparam int WA_W  = AW - OFF_W;

  logic          rst_ns;
  lsu_state_e    state;
  logic          accept;
  logic          split;

  req_attr_t         attr_q;
  logic [OFF_W-1:0]  off_q;
  logic [WA_W-1:0]   word_q;
  logic [DW-1:0]     wdata_q;
  logic [DW-1:0]     lo_buf_q;
  logic [DW-1:0]     load_q;
  logic              done_q;

  logic [2*NB-1:0]   win_be;
  logic [2*DW-1:0]   win_data;
  logic [2*DW-1:0]   rd_window;
  logic [DW-1:0]     gathered;

  lsu_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_ns)
  );

  assign busy   = (state != ST_IDLE);
  assign accept = req_valid & ~busy;
  assign split  = (int'(off_q) + int'(width_bytes(attr_q.size))) > NB;

  lsu_ctrl u_ctrl (
    .clk   (clk),
    .rst_n (rst_ns),
    .start (accept),
    .split (split),
    .state (state)
  );

  // request capture, enabled on acceptance only
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      attr_q  <= '0;
      off_q   <= '0;
      word_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      attr_q  <= '{wr: req_write, size: opsize_e'(req_size), sgn: req_signed, big: req_big};
      off_q   <= req_addr[OFF_W-1:0];
      word_q  <= req_addr[AW-1:OFF_W];
      wdata_q <= req_wdata;
    end
  end

  lsu_store_steer #(.NB(NB), .OFF_W(OFF_W)) u_steer (
    .off      (off_q),
    .size     (attr_q.size),
    .big      (attr_q.big),
    .wdata    (wdata_q),
    .win_be   (win_be),
    .win_data (win_data)
  );

  // memory side, driven from state and captured request
  always_comb begin
    mem_en    = 1'b0;
    mem_addr  = word_q;
    mem_be    = '0;
    mem_wdata = '0;
    unique case (state)
      ST_LO: begin
        mem_en    = 1'b1;
        mem_be    = win_be[NB-1:0];
        mem_wdata = win_data[DW-1:0];
      end
      ST_HI: begin
        mem_en    = 1'b1;
        mem_addr  = word_q + 1'b1;
        mem_be    = win_be[2*NB-1:NB];
        mem_wdata = win_data[2*DW-1:DW];
      end
      default: ;
    endcase
    mem_we = mem_en & attr_q.wr;
  end

  // first word of a split load arrives while the second cycle is issued
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)              lo_buf_q <= '0;
    else if (state == ST_HI)  lo_buf_q <= mem_rdata;
  end

  assign rd_window = split ? {mem_rdata, lo_buf_q} : {{DW{1'b0}}, mem_rdata};

  lsu_load_gather #(.NB(NB), .OFF_W(OFF_W)) u_gather (
    .off    (off_q),
    .size   (attr_q.size),
    .big    (attr_q.big),
    .sgn    (attr_q.sgn),
    .window (rd_window),
    .result (gathered)
  );

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      load_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= (state == ST_FIN);
      if (state == ST_FIN && !attr_q.wr) load_q <= gathered;
    end
  end

  assign done      = done_q;
  assign load_data = load_q;

endmodule

// File: rtl/lsu_checker.sv
`timescale 1ns/1ps
module lsu_checker #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          busy,
  input logic          done,
  input logic          mem_en,
  input logic          mem_we,
  input logic [AW-4:0] mem_addr,
  input logic [7:0]    mem_be
);

  p_accept_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy) |=> busy);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_we_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_en);

  p_lanes_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> (mem_be != 8'h00));

  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_en);

  p_next_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && $past(mem_en)) |-> (mem_addr == $past(mem_addr) + 1'b1));

endmodule

bind endian_lsu lsu_checker #(.AW(AW)) u_lsu_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .busy      (busy),
  .done      (done),
  .mem_en    (mem_en),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_be    (mem_be)
);

// File: tb/test_endian_lsu.sv
`timescale 1ns/1ps
module test_endian_lsu;

  localparam int AW   = 16;
  localparam int MEMB = 2048;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, req_signed, req_big;
  logic [1:0]  req_size;
  logic [AW-1:0] req_addr;
  logic [63:0] req_wdata;
  logic        busy, done, mem_en, mem_we;
  logic [63:0] load_data, mem_wdata, mem_rdata;
  logic [AW-4:0] mem_addr;
  logic [7:0]  mem_be;

  logic [63:0] mem [256];
  logic [7:0]  shadow [MEMB];
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  endian_lsu #(.AW(AW), .DW(64)) i_endian_lsu (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_signed(req_signed), .req_big(req_big),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
    .load_data(load_data), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin
        for (int j = 0; j < 8; j++)
          if (mem_be[j]) mem[mem_addr[7:0]][j*8 +: 8] <= mem_wdata[j*8 +: 8];
      end else begin
        mem_rdata <= mem[mem_addr[7:0]];
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_load(input logic [1:0] sz, input int addr, input bit sgn, input bit big);
    int n;
    logic [63:0] v;
    n = 1 << sz;
    v = '0;
    for (int k = 0; k < n; k++)
      v[k*8 +: 8] = shadow[(addr + (big ? n - 1 - k : k)) % MEMB];
    if (sgn && v[8*n-1])
      for (int b = 8*n; b < 64; b++) v[b] = 1'b1;
    return v;
  endfunction

  function automatic logic [7:0] op_byte(input logic [63:0] wd, input int n, input int i, input bit big);
    return wd[(big ? n - 1 - i : i)*8 +: 8];
  endfunction

  task automatic do_op(input bit wr, input logic [1:0] sz, input int addr, input bit sgn,
                       input bit big, input logic [63:0] wd, input bit intrude);
    int n, off, accn, c, iaddr;
    bit split;
    logic [15:0] wbe;
    logic [63:0] expv;
    logic [63:0] iword;
    n = 1 << sz;
    off = addr % 8;
    split = (off + n) > 8;
    wbe = 16'(((1 << n) - 1) << off);
    expv = exp_load(sz, addr, sgn, big);
    iaddr = (addr ^ 11'h400) & ~7;
    iword = mem[iaddr / 8];
    req_valid = 1'b1; req_write = wr; req_size = sz; req_signed = sgn;
    req_big = big; req_addr = AW'(addr); req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    if (intrude) begin
      req_write = 1'b1; req_addr = AW'(iaddr); req_wdata = ~wd; req_size = 2'd3;
    end else begin
      req_valid = 1'b0;
    end
    accn = 0;
    c = 1;
    chk(busy === 1'b1, "R8 busy after accept", 64'(busy), 64'd1);
    while (c < 12) begin
      if (mem_en) begin
        accn++;
        chk(mem_addr[7:0] == 8'((addr / 8 + accn - 1) % 256), "R5 word order",
            64'(mem_addr[7:0]), 64'((addr / 8 + accn - 1) % 256));
        chk(mem_be == (accn == 1 ? wbe[7:0] : wbe[15:8]), "R7 lane enables",
            64'(mem_be), 64'(accn == 1 ? wbe[7:0] : wbe[15:8]));
        chk(mem_we == wr, "R7 write strobe", 64'(mem_we), 64'(wr));
        if (wr)
          for (int j = 0; j < 8; j++) begin
            int p;
            p = j + 8 * (accn - 1);
            if (p >= off && p < off + n)
              chk(mem_wdata[j*8 +: 8] == op_byte(wd, n, p - off, big),
                  big ? "R3 store lane data" : "R2 store lane data",
                  64'(mem_wdata[j*8 +: 8]), 64'(op_byte(wd, n, p - off, big)));
          end
      end
      if (done) break;
      @(negedge clk);
      c++;
    end
    req_valid = 1'b0;
    chk(accn == (split ? 2 : 1), split ? "R5 two memory cycles" : "R4 one memory cycle",
        64'(accn), 64'(split ? 2 : 1));
    chk(c == (split ? 4 : 3), "R4 R5 done latency", 64'(c), 64'(split ? 4 : 3));
    if (!wr) begin
      chk(load_data == expv, sgn ? "R6 signed load" : (big ? "R3 load order" : "R2 load order"),
          load_data, expv);
    end else begin
      for (int i = 0; i < n; i++) shadow[(addr + i) % MEMB] = op_byte(wd, n, i, big);
    end
    if (intrude)
      chk(mem[iaddr / 8] == iword, "R8 ignored request left memory alone", mem[iaddr / 8], iword);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] wd;
    void'($urandom(32'h5eed_1234));
    for (int w = 0; w < 256; w++) begin
      mem[w] = {$urandom, $urandom};
      for (int b = 0; b < 8; b++) shadow[w*8 + b] = mem[w][b*8 +: 8];
    end
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_size = 2'd0;
    req_signed = 1'b0; req_big = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0 && mem_en == 1'b0, "R10 reset outputs quiet",
        64'({busy, done, mem_en}), 64'd0);
    chk(load_data == 64'd0, "R10 reset load_data", load_data, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy == 1'b0, "R10 idle after reset", 64'(busy), 64'd0);

    // R1 R2: little-endian double word across a word boundary, read back piecewise
    do_op(1'b1, 2'd3, 16'h15, 1'b0, 1'b0, 64'h0102_0304_0506_0708, 1'b0);
    do_op(1'b0, 2'd3, 16'h15, 1'b0, 1'b0, 64'h0, 1'b0);
    chk(load_data == 64'h0102_0304_0506_0708, "R2 dword round trip", load_data, 64'h0102_0304_0506_0708);
    do_op(1'b0, 2'd0, 16'h15, 1'b0, 1'b0, 64'h0, 1'b0);
    chk(load_data == 64'h08, "R2 lowest address holds LSB", load_data, 64'h08);
    // R3: big-endian aligned store, byte at base is the MSB
    do_op(1'b1, 2'd3, 16'h40, 1'b0, 1'b1, 64'h1122_3344_5566_7788, 1'b0);
    do_op(1'b0, 2'd0, 16'h40, 1'b0, 1'b0, 64'h0, 1'b0);
    chk(load_data == 64'h11, "R3 lowest address holds MSB", load_data, 64'h11);
    do_op(1'b0, 2'd1, 16'h47, 1'b0, 1'b1, 64'h0, 1'b0);
    // R6: sign and zero fill
    do_op(1'b1, 2'd0, 16'h100, 1'b0, 1'b0, 64'h80, 1'b0);
    do_op(1'b0, 2'd0, 16'h100, 1'b1, 1'b0, 64'h0, 1'b0);
    chk(load_data == 64'hFFFF_FFFF_FFFF_FF80, "R6 sign fill byte", load_data, 64'hFFFF_FFFF_FFFF_FF80);
    do_op(1'b0, 2'd0, 16'h100, 1'b0, 1'b0, 64'h0, 1'b0);
    chk(load_data == 64'h80, "R6 zero fill byte", load_data, 64'h80);
    // R5: half word at offset 7 split, word at offset 6
    do_op(1'b1, 2'd1, 16'h1F, 1'b0, 1'b1, 64'hBEEF, 1'b0);
    do_op(1'b0, 2'd1, 16'h1F, 1'b1, 1'b1, 64'h0, 1'b0);
    chk(load_data == 64'hFFFF_FFFF_FFFF_BEEF, "R5 split half signed", load_data, 64'hFFFF_FFFF_FFFF_BEEF);
    do_op(1'b1, 2'd2, 16'h7FE, 1'b0, 1'b0, 64'hCAFE_F00D, 1'b0);
    // R8: request held while busy is ignored
    do_op(1'b1, 2'd2, 16'h26, 1'b0, 1'b0, 64'h1357_9BDF, 1'b1);
    do_op(1'b0, 2'd3, 16'h23, 1'b0, 1'b1, 64'h0, 1'b1);

    // R1 R9: random back-to-back traffic
    for (int t = 0; t < 600; t++) begin
      wd = {$urandom, $urandom};
      do_op(1'($urandom % 3 == 0), 2'($urandom), int'($urandom % MEMB), 1'($urandom),
            1'($urandom), wd, 1'($urandom % 16 == 0));
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule